// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous single-port memory of 36-bit words, each word split into four 9-bit lanes (eight data bits and one parity bit). Addresses and commands are registered on the rising clock edge. Write data follows its address by one clock, so the shared data bus can switch between reads and writes on every cycle with no idle cycle in between.

A command is loaded on an edge where `load_n` is low. On that edge `wr_n`, the byte strobes and the three chip selects are sampled. When `load_n` is high, the last loaded operation continues as a four-beat burst, and its address sequence is either linear or interleaved. Write data goes first into a pending-write register and reaches the array one enabled edge later. A read of a location that is still pending is served from that register, merged lane by lane.

A clock-enable input freezes the whole pipeline. An asynchronous output enable and a snooze input can each force the bus off, and the array keeps its contents during snooze. Read data flows through combinationally. It is presented in the cycle after the load edge and is valid to be sampled at the next edge.

Top module: `lw_sram`

## Requirements
- R1: A load (`load_n`=0) of a selected device with `wr_n`=1 is a read. During the cycle after that edge, `d_oe`=1 and `d_out` holds the word stored at `addr`.
- R2: A load with `wr_n`=0 is a write. The address and `byte_wr_n` are taken at the load edge and `d_in` at the next enabled edge. Lane i, bits [9i+8:9i], is written only when `byte_wr_n[i]`=0. With all four strobes high the write is an abort and changes nothing.
- R3: A read returns the newest data of its address, including data given on the same edge as the read's load and data from writes issued back to back.
- R4: The device is selected only when `sel0_n`=0, `sel1_n`=0 and `sel2`=1 at a load edge. Otherwise the cycle is a deselect with `d_oe`=0, and continue edges (`load_n`=1) after a deselect stay deselected.
- R5: With `load_n`=1, the operation type of the last load continues and `wr_n`, `addr` and the selects are ignored. The low two address bits at beat k follow (base+k) mod 4 when `seq_ilv`=0 and base XOR k when `seq_ilv`=1, wrapping after four beats. The upper address bits are fixed.
- R6: An edge with `clk_en_n`=1 changes nothing. No write data is taken, a read keeps driving the same word, and a write keeps the bus off.
- R7: `oe_n`=1 forces `d_oe`=0 without waiting for a clock. Write cycles never drive the bus.
- R8: While `sleep`=1 all other inputs are ignored, `d_oe`=0 and the array keeps its contents.
- R9: On the first enabled edge after `sleep` falls, a write load is treated as a deselect. A read load is accepted.
- R10: After reset, `d_oe`=0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the edge |
| load_n | input | 1 | Active-low command load; high continues a burst |
| wr_n | input | 1 | Low selects write at a load |
| byte_wr_n | input | 4 | Active-low lane write strobes |
| sel0_n | input | 1 | Active-low chip select |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Snooze request, active high |
| seq_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | 6 | Word address |
| d_in | input | 36 | Input half of the data bus |
| d_out | output | 36 | Output half of the data bus |
| d_oe | output | 1 | Bus drive enable |

## Verification
A read loaded at edge k is due on `d_out`/`d_oe` during the cycle that follows, so the monitor samples 3 ns after edge k. A write loaded at edge k takes its data at edge k+1, and from then on the reference model holds the new lane values, so a read loaded on that same edge must already see them. The driver applies each command at the falling edge, advances a behavioural model of the command pipeline for the coming rising edge, and queues the expected bus state for that edge. Stalled and snooze edges queue the held or quiet state, so every cycle has exactly one expectation, which is popped in step with the design.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 9;

endpackage

// File: rtl/lw_burst_seq.sv
module lw_burst_seq #(
    parameter int BITS = 2
) (
    input  logic [BITS-1:0] base,
    input  logic [BITS-1:0] step,
    input  logic            interleave,
    output logic [BITS-1:0] addr_lo
);

    logic [BITS-1:0] lin_lo;
    logic [BITS-1:0] ilv_lo;

    always_comb begin
        lin_lo  = base + step;
        ilv_lo  = base ^ step;
        addr_lo = interleave ? ilv_lo : lin_lo;
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter  int DEPTH  = 64,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int AW     = $clog2(DEPTH),
    localparam int DW     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wmask,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_wr_merge.sv
module lw_wr_merge #(
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DW     = LANES * LANE_W
) (
    input  logic [DW-1:0]    arr_data,
    input  logic             hit,
    input  logic [LANES-1:0] pend_mask,
    input  logic [DW-1:0]    pend_data,
    output logic [DW-1:0]    merged
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = (hit && pend_mask[l])
                                          ? pend_data[l*LANE_W +: LANE_W]
                                          : arr_data[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter  int DEPTH      = 64,
    parameter  int LANES      = DEF_LANES,
    parameter  int LANE_W     = DEF_LANE_W,
    parameter  int BURST_BITS = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int DW         = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             load_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] byte_wr_n,
    input  logic             sel0_n,
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic             seq_ilv,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    d_in,
    output logic [DW-1:0]    d_out,
    output logic             d_oe
);

    typedef struct packed {
        op_e                   op;
        logic [AW-1:0]         base;
        logic [BURST_BITS-1:0] cnt;
        logic [LANES-1:0]      mask;
        logic                  wake;
        logic                  pv;
        logic [AW-1:0]         pa;
        logic [LANES-1:0]      pm;
        logic [DW-1:0]         pd;
    } st_t;

    st_t st_d, st_q;

    logic                  edge_go;
    logic                  selected;
    logic [BURST_BITS-1:0] seq_lo;
    logic [AW-1:0]         cur_addr;
    logic [DW-1:0]         arr_data;
    logic                  hit;

    assign edge_go  = !sleep && !clk_en_n;
    assign selected = !sel0_n && !sel1_n && sel2;

    lw_burst_seq #(.BITS(BURST_BITS)) u_seq (
        .base       (st_q.base[BURST_BITS-1:0]),
        .step       (st_q.cnt),
        .interleave (seq_ilv),
        .addr_lo    (seq_lo)
    );

    assign cur_addr = {st_q.base[AW-1:BURST_BITS], seq_lo};

    lw_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (edge_go && st_q.pv),
        .waddr (st_q.pa),
        .wmask (st_q.pm),
        .wdata (st_q.pd),
        .raddr (cur_addr),
        .rdata (arr_data)
    );

    assign hit = st_q.pv && (st_q.pa == cur_addr);

    lw_wr_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .arr_data  (arr_data),
        .hit       (hit),
        .pend_mask (st_q.pm),
        .pend_data (st_q.pd),
        .merged    (d_out)
    );

    assign d_oe = !oe_n && !sleep && (st_q.op == OP_RD);

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d.op   = OP_IDLE;
            st_d.wake = 1'b1;
        end else if (!clk_en_n) begin
            // data phase of the write loaded one enabled edge ago
            st_d.pv = (st_q.op == OP_WR) && (st_q.mask != '0);
            st_d.pa = cur_addr;
            st_d.pm = st_q.mask;
            st_d.pd = d_in;
            if (!load_n) begin
                if (!selected) begin
                    st_d.op = OP_IDLE;
                end else if (wr_n) begin
                    st_d.op = OP_RD;
                end else if (st_q.wake) begin
                    st_d.op = OP_IDLE;
                end else begin
                    st_d.op = OP_WR;
                end
                st_d.base = addr;
                st_d.cnt  = '0;
                st_d.mask = ~byte_wr_n;
            end else if (st_q.op != OP_IDLE) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.wake = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    rd_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !sleep && d_oe) |=> (oe_n || sleep || (d_oe && $stable(d_out))));

    // R2
    abort_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_go && st_q.op == OP_WR && st_q.mask == '0) |=> !st_q.pv);

    // R7
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_go && !load_n && !wr_n && selected) |=> !d_oe);

    // R4
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_go && !load_n && !selected) |=> !d_oe);

    // R5
    burst_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_go && load_n) |=> (st_q.op == $past(st_q.op)));

    // R8
    snooze_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st_q.op == OP_IDLE));

    // R9
    wake_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_go && st_q.wake && !load_n) |=> (st_q.op != OP_WR));

endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int DW    = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n, load_n, wr_n, sel0_n, sel1_n, sel2;
    logic          oe_n, sleep, seq_ilv;
    logic [3:0]    byte_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in, d_out;
    logic          d_oe;

    always #5 clk = ~clk;

    lw_sram u_lw_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .wr_n(wr_n), .byte_wr_n(byte_wr_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
        .sel2(sel2), .oe_n(oe_n), .sleep(sleep), .seq_ilv(seq_ilv),
        .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // scoreboard queues
    bit          q_oe  [$];
    logic [35:0] q_dat [$];
    string       q_req [$];

    // behavioural model of the command pipeline
    int          m_op = 0;   // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;
    logic [3:0]  m_mask = '0;
    bit          m_wake = 0;
    logic [35:0] ref_mem [DEPTH];
    logic [35:0] last_rd = '0;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = seq_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [35:0] pat(int i);
        return 36'(i * 36'h1234567 + 36'h0ABCDE);
    endfunction

    task automatic step(bit cen, bit ld, bit w, logic [3:0] bw, logic [2:0] cs,
                        bit oe, bit zz, logic [AW-1:0] a, logic [35:0] din, string req);
        logic [AW-1:0] wa;
        @(negedge clk);
        clk_en_n = cen; load_n = ld; wr_n = w; byte_wr_n = bw;
        {sel0_n, sel1_n, sel2} = cs; oe_n = oe; sleep = zz; addr = a; d_in = din;
        if (zz) begin
            m_op = 0; m_wake = 1;
        end else if (!cen) begin
            if (m_op == 2) begin
                wa = m_addr();
                for (int l = 0; l < 4; l++)
                    if (m_mask[l]) ref_mem[wa][l*9 +: 9] = din[l*9 +: 9];
            end
            if (!ld) begin
                if (cs != 3'b001) m_op = 0;
                else if (w)       m_op = 1;
                else if (m_wake)  m_op = 0;
                else              m_op = 2;
                m_base = a; m_cnt = '0; m_mask = ~bw;
            end else if (m_op != 0) begin
                m_cnt = m_cnt + 2'd1;
            end
            m_wake = 0;
            if (m_op == 1) last_rd = ref_mem[m_addr()];
        end
        q_oe.push_back((m_op == 1) && !oe && !zz);
        q_dat.push_back(last_rd);
        q_req.push_back(req);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [35:0] din, string req);
        step(0, 0, 1, 4'hF, 3'b001, 0, 0, a, din, req);
    endtask
    task automatic wr(logic [AW-1:0] a, logic [3:0] bw, logic [35:0] din, string req);
        step(0, 0, 0, bw, 3'b001, 0, 0, a, din, req);
    endtask
    task automatic nxt(bit w, logic [35:0] din, string req);
        step(0, 1, w, 4'h0, 3'b110, 0, 0, 6'h3F, din, req);
    endtask
    task automatic idle(logic [35:0] din, string req);
        step(0, 0, 1, 4'hF, 3'b101, 0, 0, '0, din, req);
    endtask
    task automatic hold(logic [35:0] din, string req);
        step(1, 0, 0, 4'h0, 3'b001, 0, 0, 6'h2A, din, req);
    endtask
    task automatic snooze(string req);
        step(0, 0, 0, 4'h0, 3'b001, 0, 1, 6'h15, 36'hFFFFFFFFF, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q_oe.size() > 0) begin
                bit e_oe; logic [35:0] e_d; string r;
                e_oe = q_oe.pop_front(); e_d = q_dat.pop_front(); r = q_req.pop_front();
                checks++;
                if (d_oe !== e_oe || (e_oe && d_out !== e_d)) begin
                    errors++;
                    $display("FAIL %s: d_oe=%b d_out=%h expected d_oe=%b d_out=%h",
                             r, d_oe, d_out, e_oe, e_d);
                end
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clk_en_n = 0; load_n = 1; wr_n = 1; byte_wr_n = 4'hF;
        {sel0_n, sel1_n, sel2} = 3'b101; oe_n = 0; sleep = 0; seq_ilv = 0;
        addr = '0; d_in = '0; rst_n = 0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10: bus off in reset
        checks++;
        if (d_oe !== 1'b0) begin
            errors++;
            $display("FAIL R10: d_oe=%b expected 0", d_oe);
        end
        rst_n = 1;
        idle('0, "R10");

        // R2: fill array with full writes
        wr(0, 4'h0, '0, "R2");
        for (int i = 1; i < DEPTH; i++) wr(AW'(i), 4'h0, pat(i-1), "R2");
        idle(pat(DEPTH-1), "R2");

        // R1: reads
        rd(5, '0, "R1"); rd(63, '0, "R1"); rd(0, '0, "R1"); idle('0, "R1");

        // R2: partial lanes and abort
        wr(7, 4'b1010, '0, "R2"); idle(36'h123456789, "R2"); rd(7, '0, "R2");
        wr(8, 4'hF, '0, "R2"); idle(36'hFEDCBA987, "R2"); rd(8, '0, "R2");

        // R3: coherency with pending data
        wr(9, 4'h0, '0, "R3"); rd(9, 36'h111111111, "R3");
        wr(9, 4'b1110, '0, "R3"); wr(9, 4'b0001, 36'h222222222, "R3");
        rd(9, 36'h333333333, "R3"); rd(9, '0, "R3");
        wr(10, 4'h0, '0, "R3"); rd(10, 36'h0DEADBEEF, "R3");
        wr(11, 4'h0, '0, "R3"); rd(10, 36'h0CAFEF00D, "R3"); rd(11, '0, "R3");

        // R5: linear burst write, wr_n ignored on continues
        seq_ilv = 0;
        wr(6'h12, 4'h0, '0, "R5");
        nxt(1, 36'hA0000000A, "R5"); nxt(1, 36'hA0000000B, "R5");
        nxt(0, 36'hA0000000C, "R5"); idle(36'hA0000000D, "R5");
        rd(6'h10, '0, "R5"); nxt(0, '0, "R5"); nxt(1, '0, "R5"); nxt(1, '0, "R5");
        nxt(1, '0, "R5");
        // R5: interleaved burst read with wrap
        idle('0, "R5");
        seq_ilv = 1;
        rd(6'h21, '0, "R5"); nxt(0, '0, "R5"); nxt(0, '0, "R5"); nxt(0, '0, "R5");
        nxt(0, '0, "R5");
        idle('0, "R5");
        seq_ilv = 0;

        // R4: each select off, then continued deselect
        step(0, 0, 1, 4'hF, 3'b101, 0, 0, 6'd5, '0, "R4");
        step(0, 0, 1, 4'hF, 3'b011, 0, 0, 6'd5, '0, "R4");
        step(0, 0, 1, 4'hF, 3'b000, 0, 0, 6'd5, '0, "R4");
        nxt(1, '0, "R4"); nxt(0, '0, "R4");

        // R6: stall during read and during write
        rd(3, '0, "R6"); hold('0, "R6"); hold('0, "R6"); idle('0, "R6");
        wr(4, 4'h0, '0, "R6"); hold(36'h0BADBADBA, "R6"); idle(36'h044444444, "R6");
        rd(4, '0, "R6");

        // R7: output enable off, writes never drive
        step(0, 0, 1, 4'hF, 3'b001, 1, 0, 6'd3, '0, "R7");
        rd(3, '0, "R7");
        wr(12, 4'h0, '0, "R7"); idle(36'h077777777, "R7");

        // R8: contents kept through snooze
        wr(20, 4'h0, '0, "R8"); idle(36'h088888888, "R8");
        snooze("R8"); snooze("R8"); snooze("R8");
        idle('0, "R8"); rd(20, '0, "R8"); idle('0, "R8");

        // R9: write on first wake edge dropped, read accepted
        snooze("R9");
        wr(21, 4'h0, '0, "R9"); idle(36'h099999999, "R9"); rd(21, '0, "R9");
        snooze("R9");
        rd(22, '0, "R9"); idle('0, "R9");

        idle('0, "R10");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule